// File: doc/BRIEF.md
# Interleaved DRAM Range Decoder

This block maps a 40-bit physical address to the node that owns it. Eight region slots each hold a start/end register pair at 16 MB granularity, programmed and read back through a small register port. A lookup presents an address and an access direction. The block returns whether some slot claims it, the 3-bit destination node of that slot and the slot's index. The result comes one clock after the request.

Each slot has separate permissions for reads and for writes. Each slot can also spread its region across 2, 4 or 8 nodes. It does this by requiring some of the address bits A[14:12] to equal a per-slot select value. A slot's permission bits become active one cycle after its start register is written. Software can therefore program the end register first, then the start register, without any lookup seeing a half-built slot.

Top module: `dram_range_decoder`

## Requirements
- R1: After reset every slot has both permissions cleared, so every lookup misses, and every register reads back as zero.
- R2: cfgAddr = {slot index, kind}, where kind 0 selects the start register and kind 1 the end register. The start word holds read-permit in bit 0, write-permit in bit 1, interleave mode in [10:8] and region start A[39:24] in [31:16]. The end word holds the node in [2:0], interleave select in [10:8] and region end A[39:24] in [31:16]. All other bits are dropped on write and read as 0. Read data appears in the cycle after cfgRdEn.
- R3: A slot covers an address when start ≤ A[39:24] ≤ end. Both bounds are inclusive.
- R4: A read lookup (reqIsWrite=0) can match a slot only if that slot's read-permit is set. A write lookup can match only if the slot's write-permit is set.
- R5: Interleave mode 001 requires A[12] to equal select bit 0. Mode 011 requires A[13:12] to equal select [1:0]. Mode 111 requires A[14:12] to equal select [2:0]. Mode 000 and every other code apply no interleave condition.
- R6: When several slots match, the lowest slot index wins. rspIndex and rspNode come from that slot.
- R7: When no slot matches, rspHit is 0 and rspNode and rspIndex are both 0.
- R8: Permission bits written into a start register take effect for a lookup presented one cycle after the write. A lookup presented in the cycle directly after the write still uses the old permissions.
- R9: rspValid is high exactly in the cycle after reqValid was sampled high. rspHit is 0 whenever rspValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgRdEn | input | 1 | Register read strobe |
| cfgAddr | input | 4 | {slot index, kind} |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, one cycle after cfgRdEn |
| reqValid | input | 1 | Lookup request |
| reqIsWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | 40 | Physical address |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Some slot matched |
| rspNode | output | 3 | Destination node of winning slot |
| rspIndex | output | 3 | Index of winning slot |

## Verification
The tests place addresses exactly on a region's end and one granule past it, which separates inclusive from exclusive bounds. They issue the same address as a read and as a write against slots with different permissions, which shows whether the direction picks the right permit bit. They use overlapping slots, which exposes the priority order. For each interleave mode they use addresses whose A[14:12] agree and disagree with the select value, including a bit outside the mode's mask, along with one undefined mode code. A lookup issued directly after a start-register write, and then one cycle later, pins down when the permission bits take effect.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  // strobes handed from the control side to the match datapath
  typedef struct packed {
    logic lookupGo;
    logic isWrite;
  } dec_strobe_t;

  // field positions inside the 32-bit configuration words
  localparam int RD_PERMIT_BIT = 0;
  localparam int WR_PERMIT_BIT = 1;
  localparam int ILV_FIELD_LO  = 8;
  localparam int ILV_FIELD_HI  = 10;
  localparam int ADDR_FIELD_LO = 16;
  localparam int ADDR_FIELD_HI = 31;

  // interleave mode code to compare mask; undefined codes mean no interleave
  function automatic logic [2:0] ilvModeMask(input logic [2:0] mode);
    case (mode)
      3'b001:  return 3'b001;
      3'b011:  return 3'b011;
      3'b111:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/dram_dec_ctrl.sv
module dram_dec_ctrl
  import dram_dec_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int REGION_W  = 16,
  parameter int NODE_W    = 3,
  localparam int IDX_W    = $clog2(NUM_PAIRS),
  localparam int CFG_AW   = IDX_W + 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfgWrEn,
  input  logic                                cfgRdEn,
  input  logic [CFG_AW-1:0]                   cfgAddr,
  input  logic [31:0]                         cfgWrData,
  output logic [31:0]                         cfgRdData,
  input  logic                                reqValid,
  input  logic                                reqIsWrite,
  output dec_strobe_t                         strobe,
  output logic [NUM_PAIRS-1:0][REGION_W-1:0]  baseAddr,
  output logic [NUM_PAIRS-1:0][REGION_W-1:0]  limitAddr,
  output logic [NUM_PAIRS-1:0][NODE_W-1:0]    nodeId,
  output logic [NUM_PAIRS-1:0][2:0]           ilvSel,
  output logic [NUM_PAIRS-1:0][2:0]           ilvMask,
  output logic [NUM_PAIRS-1:0]                rdArmed,
  output logic [NUM_PAIRS-1:0]                wrArmed
);

  logic [NUM_PAIRS-1:0]      rdPermit;
  logic [NUM_PAIRS-1:0]      wrPermit;
  logic [NUM_PAIRS-1:0][2:0] ilvMode;
  logic [IDX_W-1:0]          selIdx;
  logic                      selLimit;
  logic [31:0]               rdWord;

  assign selIdx   = cfgAddr[CFG_AW-1:1];
  assign selLimit = cfgAddr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr  <= '0;
      limitAddr <= '0;
      nodeId    <= '0;
      ilvSel    <= '0;
      ilvMode   <= '0;
      rdPermit  <= '0;
      wrPermit  <= '0;
    end else if (cfgWrEn) begin
      if (selLimit) begin
        limitAddr[selIdx] <= cfgWrData[ADDR_FIELD_HI:ADDR_FIELD_LO];
        ilvSel[selIdx]    <= cfgWrData[ILV_FIELD_HI:ILV_FIELD_LO];
        nodeId[selIdx]    <= cfgWrData[NODE_W-1:0];
      end else begin
        baseAddr[selIdx]  <= cfgWrData[ADDR_FIELD_HI:ADDR_FIELD_LO];
        ilvMode[selIdx]   <= cfgWrData[ILV_FIELD_HI:ILV_FIELD_LO];
        rdPermit[selIdx]  <= cfgWrData[RD_PERMIT_BIT];
        wrPermit[selIdx]  <= cfgWrData[WR_PERMIT_BIT];
      end
    end
  end

  // permissions reach the match logic one cycle after the start register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdArmed <= '0;
      wrArmed <= '0;
    end else begin
      rdArmed <= rdPermit;
      wrArmed <= wrPermit;
    end
  end

  generate
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_mask
      assign ilvMask[g] = ilvModeMask(ilvMode[g]);
    end
  endgenerate

  always_comb begin
    rdWord = '0;
    if (selLimit) begin
      rdWord[ADDR_FIELD_HI:ADDR_FIELD_LO] = limitAddr[selIdx];
      rdWord[ILV_FIELD_HI:ILV_FIELD_LO]   = ilvSel[selIdx];
      rdWord[NODE_W-1:0]                  = nodeId[selIdx];
    end else begin
      rdWord[ADDR_FIELD_HI:ADDR_FIELD_LO] = baseAddr[selIdx];
      rdWord[ILV_FIELD_HI:ILV_FIELD_LO]   = ilvMode[selIdx];
      rdWord[RD_PERMIT_BIT]               = rdPermit[selIdx];
      rdWord[WR_PERMIT_BIT]               = wrPermit[selIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cfgRdData <= '0;
    else if (cfgRdEn) cfgRdData <= rdWord;
  end

  assign strobe.lookupGo = reqValid;
  assign strobe.isWrite  = reqIsWrite;

  // a start-register write never disturbs the end-register fields
  assert_start_write_keeps_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !cfgAddr[0]) |=> ($stable(limitAddr) && $stable(nodeId) && $stable(ilvSel)));

  // armed permissions trail the programmed ones: a fresh permit is not yet armed
  assert_permit_arms_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdPermit[0]) |-> !rdArmed[0]);

endmodule

// File: rtl/dram_dec_match.sv
module dram_dec_match
  import dram_dec_pkg::*;
#(
  parameter int NUM_PAIRS  = 8,
  parameter int ADDR_W     = 40,
  parameter int REGION_LSB = 24,
  parameter int ILV_LSB    = 12,
  parameter int NODE_W     = 3,
  localparam int REGION_W  = ADDR_W - REGION_LSB,
  localparam int IDX_W     = $clog2(NUM_PAIRS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  dec_strobe_t                         strobe,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [NUM_PAIRS-1:0][REGION_W-1:0]  baseAddr,
  input  logic [NUM_PAIRS-1:0][REGION_W-1:0]  limitAddr,
  input  logic [NUM_PAIRS-1:0][NODE_W-1:0]    nodeId,
  input  logic [NUM_PAIRS-1:0][2:0]           ilvSel,
  input  logic [NUM_PAIRS-1:0][2:0]           ilvMask,
  input  logic [NUM_PAIRS-1:0]                rdArmed,
  input  logic [NUM_PAIRS-1:0]                wrArmed,
  output logic                                rspValid,
  output logic                                rspHit,
  output logic [NODE_W-1:0]                   rspNode,
  output logic [IDX_W-1:0]                    rspIndex
);

  logic [REGION_W-1:0]  region;
  logic [2:0]           ilvBits;
  logic [NUM_PAIRS-1:0] hitVec;
  logic                 anyHit;
  logic [IDX_W-1:0]     winIdx;

  assign region  = reqAddr[ADDR_W-1:REGION_LSB];
  assign ilvBits = reqAddr[ILV_LSB+2:ILV_LSB];

  generate
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_slot
      logic inRange, typeOk, ilvOk;
      assign inRange  = (region >= baseAddr[g]) && (region <= limitAddr[g]);
      assign typeOk   = strobe.isWrite ? wrArmed[g] : rdArmed[g];
      assign ilvOk    = ((ilvBits ^ ilvSel[g]) & ilvMask[g]) == 3'b000;
      assign hitVec[g] = inRange && typeOk && ilvOk;
    end
  endgenerate

  // scan downward so the lowest matching index is the last one kept
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspNode  <= '0;
      rspIndex <= '0;
    end else begin
      rspValid <= strobe.lookupGo;
      rspHit   <= strobe.lookupGo && anyHit;
      rspNode  <= (strobe.lookupGo && anyHit) ? nodeId[winIdx] : '0;
      rspIndex <= (strobe.lookupGo && anyHit) ? winIdx : '0;
    end
  end

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lookupGo |=> rspValid);

  assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> !rspHit);

  assert_miss_zero_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspHit) |-> (rspNode == '0 && rspIndex == '0));

  assert_unpermitted_read_misses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lookupGo && !strobe.isWrite && rdArmed == '0) |=> !rspHit);

endmodule

// File: rtl/dram_range_decoder.sv
module dram_range_decoder
  import dram_dec_pkg::*;
#(
  parameter int NUM_PAIRS  = 8,
  parameter int ADDR_W     = 40,
  parameter int REGION_LSB = 24,
  parameter int ILV_LSB    = 12,
  parameter int NODE_W     = 3,
  localparam int REGION_W  = ADDR_W - REGION_LSB,
  localparam int IDX_W     = $clog2(NUM_PAIRS),
  localparam int CFG_AW    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [NODE_W-1:0] rspNode,
  output logic [IDX_W-1:0]  rspIndex
);

  dec_strobe_t                        strobe;
  logic [NUM_PAIRS-1:0][REGION_W-1:0] baseAddr;
  logic [NUM_PAIRS-1:0][REGION_W-1:0] limitAddr;
  logic [NUM_PAIRS-1:0][NODE_W-1:0]   nodeId;
  logic [NUM_PAIRS-1:0][2:0]          ilvSel;
  logic [NUM_PAIRS-1:0][2:0]          ilvMask;
  logic [NUM_PAIRS-1:0]               rdArmed;
  logic [NUM_PAIRS-1:0]               wrArmed;

  dram_dec_ctrl #(
    .NUM_PAIRS(NUM_PAIRS), .REGION_W(REGION_W), .NODE_W(NODE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqIsWrite(reqIsWrite), .strobe(strobe),
    .baseAddr(baseAddr), .limitAddr(limitAddr), .nodeId(nodeId),
    .ilvSel(ilvSel), .ilvMask(ilvMask), .rdArmed(rdArmed), .wrArmed(wrArmed)
  );

  dram_dec_match #(
    .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB),
    .ILV_LSB(ILV_LSB), .NODE_W(NODE_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqAddr(reqAddr),
    .baseAddr(baseAddr), .limitAddr(limitAddr), .nodeId(nodeId),
    .ilvSel(ilvSel), .ilvMask(ilvMask), .rdArmed(rdArmed), .wrArmed(wrArmed),
    .rspValid(rspValid), .rspHit(rspHit), .rspNode(rspNode), .rspIndex(rspIndex)
  );

endmodule

// File: tb/dram_range_decoder_bench.sv
`timescale 1ns/1ps
module dram_range_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic        reqIsWrite = 1'b0;
  logic [39:0] reqAddr = '0;
  logic        rspValid, rspHit;
  logic [2:0]  rspNode, rspIndex;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dram_range_decoder u_dram_range_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspNode(rspNode), .rspIndex(rspIndex)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input int slot, input bit isEnd, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = {slot[2:0], isEnd};
    cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn   = 1'b0;
  endtask

  task automatic readReg(input int slot, input bit isEnd, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfgRdEn = 1'b1;
    cfgAddr = {slot[2:0], isEnd};
    @(posedge clk); #1;
    cfgRdEn = 1'b0;
    check(req, 64'(cfgRdData), 64'(exp));
  endtask

  task automatic lookup(input logic [39:0] addr, input bit isWr, input bit expHit,
                        input int expNode, input int expIdx, input string req);
    @(negedge clk);
    reqValid   = 1'b1;
    reqIsWrite = isWr;
    reqAddr    = addr;
    @(posedge clk); #1;
    reqValid   = 1'b0;
    check({req, " valid"}, 64'(rspValid), 64'd1);
    check({req, " hit"},   64'(rspHit),   64'(expHit));
    check({req, " node"},  64'(rspNode),  64'(expNode));
    check({req, " index"}, 64'(rspIndex), 64'(expIdx));
  endtask

  task automatic testReset();
    lookup(40'h00_0000_0000, 1'b0, 1'b0, 0, 0, "R1 reset read miss");
    lookup(40'h00_0000_0000, 1'b1, 1'b0, 0, 0, "R1 reset write miss");
    readReg(0, 1'b0, 32'h0, "R1 reset start word");
    readReg(0, 1'b1, 32'h0, "R1 reset end word");
    @(negedge clk);
    check("R9 idle no valid", 64'(rspValid), 64'd0);
    check("R9 idle no hit",   64'(rspHit),   64'd0);
  endtask

  task automatic testArming();
    writeReg(0, 1'b1, 32'h003F_0005);
    writeReg(0, 1'b0, 32'h0000_0003);
    lookup(40'h00_0000_1000, 1'b0, 1'b0, 0, 0, "R8 lookup right after start write");
    lookup(40'h00_0000_1000, 1'b0, 1'b1, 5, 0, "R8 lookup one cycle later");
  endtask

  task automatic testReadback();
    readReg(0, 1'b1, 32'h003F_0005, "R2 end word readback");
    readReg(0, 1'b0, 32'h0000_0003, "R2 start word readback");
    writeReg(7, 1'b0, 32'h1234_F7FF);
    readReg(7, 1'b0, 32'h1234_0703, "R2 reserved bits dropped");
  endtask

  task automatic testRange();
    lookup(40'h00_3FFF_FFFF, 1'b0, 1'b1, 5, 0, "R3 end bound inclusive");
    lookup(40'h00_4000_0000, 1'b0, 1'b0, 0, 0, "R3 past end misses");
    lookup(40'h00_4000_0000, 1'b1, 1'b0, 0, 0, "R7 miss outputs zero");
  endtask

  task automatic testPermits();
    writeReg(1, 1'b1, 32'h007F_0002);
    writeReg(1, 1'b0, 32'h0040_0001);
    writeReg(2, 1'b1, 32'h0040_0003);
    writeReg(2, 1'b0, 32'h0040_0002);
    @(negedge clk);
    lookup(40'h00_4000_0000, 1'b0, 1'b1, 2, 1, "R4 read uses read-permit slot");
    lookup(40'h00_4000_0000, 1'b1, 1'b1, 3, 2, "R4 write skips read-only slot");
    lookup(40'h00_5000_0000, 1'b1, 1'b0, 0, 0, "R4 write to read-only region misses");
  endtask

  task automatic testPriority();
    writeReg(3, 1'b1, 32'h003F_0006);
    writeReg(3, 1'b0, 32'h0000_0003);
    @(negedge clk);
    lookup(40'h00_0000_0000, 1'b0, 1'b1, 5, 0, "R6 lowest index wins");
    writeReg(0, 1'b0, 32'h0000_0000);
    @(negedge clk);
    lookup(40'h00_0000_0000, 1'b0, 1'b1, 6, 3, "R6 next slot after disable");
  endtask

  task automatic testInterleave();
    writeReg(4, 1'b1, 32'h01FF_0204);
    writeReg(4, 1'b0, 32'h0100_0303);
    writeReg(5, 1'b1, 32'h02FF_0101);
    writeReg(5, 1'b0, 32'h0200_0103);
    writeReg(6, 1'b1, 32'h03FF_0507);
    writeReg(6, 1'b0, 32'h0300_0703);
    @(negedge clk);
    lookup(40'h01_0000_2000, 1'b0, 1'b1, 4, 4, "R5 mode 011 match");
    lookup(40'h01_0000_6000, 1'b0, 1'b1, 4, 4, "R5 mode 011 ignores A14");
    lookup(40'h01_0000_3000, 1'b0, 1'b0, 0, 0, "R5 mode 011 mismatch");
    lookup(40'h02_0000_1000, 1'b1, 1'b1, 1, 5, "R5 mode 001 match");
    lookup(40'h02_0000_0000, 1'b1, 1'b0, 0, 0, "R5 mode 001 mismatch");
    lookup(40'h03_0000_5000, 1'b0, 1'b1, 7, 6, "R5 mode 111 match");
    lookup(40'h03_0000_4000, 1'b0, 1'b0, 0, 0, "R5 mode 111 mismatch");
    writeReg(5, 1'b0, 32'h0200_0203);
    @(negedge clk);
    lookup(40'h02_0000_0000, 1'b1, 1'b1, 1, 5, "R5 undefined mode no interleave");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testArming();
    testReadback();
    testRange();
    testPermits();
    testPriority();
    testInterleave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule